// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus that behaves like a small 16-word by 8-bit non-volatile memory. A fast system clock samples the bus clock and data lines. Each line is synchronised and then passed through a glitch filter. The filtered lines are decoded into clock edges and into START and STOP conditions. A protocol state machine receives a control byte, a word address and a data byte, and acknowledges each byte on the ninth clock. It can also return stored bytes, one after another, to the bus master.

A write is held as pending until the STOP that ends it. At that STOP the byte is committed to the storage array and a programming interval begins. For the length of that interval the slave gives no acknowledge to any byte. Whenever the slave changes its data output as a transmitter, it waits a fixed number of system clocks after the filtered bus clock falls. This keeps its transitions out of the bus clock high phase. The data output is an open-drain enable, where 1 pulls the line low.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and every storage word reads as 0x00.
- R2: A falling data line while the bus clock is high (START) begins a new command at any point and discards any pending write. The next eight bits are taken as the control byte.
- R3: A rising data line while the bus clock is high (STOP) returns the slave to idle and releases `sda_oe`. If a write is pending, the STOP commits that byte to storage.
- R4: The control byte is acknowledged only when its upper nibble (bits 7..4) equals DEV_CODE, default 4'b1010. Bits 3..1 are ignored, and bit 0 selects read (1) or write (0). A non-matching control byte gets no acknowledge, and the slave ignores the bus until the next START.
- R5: In a write, the byte after the control byte is the word address, and its low 4 bits are used. Exactly one data byte is acknowledged, and any further data byte in the same command gets no acknowledge. The data byte is stored only at STOP; a repeated START before the STOP drops it.
- R6: For WR_CYC system clocks after a committing STOP, the slave acknowledges nothing. After that interval it responds normally.
- R7: An acknowledge holds `sda_oe` at 1 for the whole high phase of the ninth bus clock. `sda_oe` never rises while the filtered bus clock is high.
- R8: The slave changes `sda_oe` HOLD_CYC system clocks after it sees a filtered bus clock fall, never sooner. START and STOP release it at once.
- R9: Reads return bytes MSB first, starting at the word pointer. The pointer advances after each byte and wraps from 15 to 0. A master acknowledge (data low) requests the next byte. A master no-acknowledge makes the slave release the line and stop sending.
- R10: A random read, made of a write command carrying only an address followed by a repeated START and a read control byte, returns the addressed word. After a committed write, the pointer holds the written address plus one.
- R11: A pulse of GLITCH_CYC system clocks or fewer on either bus line has no effect. A level must persist for more than GLITCH_CYC clocks to be accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain pull-down enable for the data line, 1 drives low |

## Verification
The hardest situation to reach from the ports is a spike that would corrupt a transfer if the filter let it through. The stimulus puts a bus clock pulse of exactly GLITCH_CYC clocks into a low phase, and a data-low pulse of the same length into the high phase of a 1 bit, both inside one data byte. An accepted clock pulse would shift the byte out of alignment. An accepted data pulse would be decoded as a START followed by a STOP, and the write would be lost. A clean readback of that byte after the programming interval shows both pulses were rejected. The programming-busy window is reached by issuing a control byte straight after a committing STOP, and then again after the interval has ended.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } tw_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } tw_events_t;

endpackage

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
    parameter int   GLITCH_CYC = 10,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          clean;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        if (q.sync[1] == q.clean) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(GLITCH_CYC)) begin
            d.clean = q.sync[1];
            d.cnt   = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= {2{IDLE_LEVEL}};
            q.clean <= IDLE_LEVEL;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign clean_o = q.clean;

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events
    import tw_eeprom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output tw_events_t ev_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ev_o.scl_rise = !q.scl && scl_i;
        ev_o.scl_fall = q.scl && !scl_i;
        ev_o.start    = q.scl && scl_i && q.sda && !sda_i;
        ev_o.stop     = q.scl && scl_i && !q.sda && sda_i;
    end

endmodule

// File: rtl/tw_word_store.sv
module tw_word_store #(
    parameter int WORDS = 16,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(WORDS)-1:0] waddr_i,
    input  logic [WIDTH-1:0]         wdata_i,
    input  logic [$clog2(WORDS)-1:0] raddr_i,
    output logic [WIDTH-1:0]         rdata_o
);
    logic [WIDTH-1:0] words_q [WORDS];
    logic [WIDTH-1:0] words_d [WORDS];

    always_comb begin
        words_d = words_q;
        if (we_i) begin
            words_d[waddr_i] = wdata_i;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[w] <= '0;
            end else begin
                words_q[w] <= words_d[w];
            end
        end
    end

    assign rdata_o = words_q[raddr_i];

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import tw_eeprom_pkg::*;
#(
    parameter int         WORDS      = 16,
    parameter logic [3:0] DEV_CODE   = 4'b1010,
    parameter int         GLITCH_CYC = 10,
    parameter int         HOLD_CYC   = 60,
    parameter int         WR_CYC     = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int AW     = $clog2(WORDS);
    localparam int BYTE_W = 8;
    localparam int HW     = $clog2(HOLD_CYC + 1);
    localparam int BW     = $clog2(WR_CYC + 1);

    typedef struct packed {
        tw_state_e         st;
        tw_state_e         nxt;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shift;
        logic [AW-1:0]     ptr;
        logic [AW-1:0]     wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic              wr_pend;
        logic              busy;
        logic [BW-1:0]     busy_cnt;
        logic [HW-1:0]     hold_cnt;
        logic              target;
        logic              oe;
    } slv_t;

    slv_t q, d;

    // line conditioning: one filter per bus line
    logic [1:0] raw_lines;
    logic [1:0] clean_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        tw_glitch_filter #(
            .GLITCH_CYC(GLITCH_CYC),
            .IDLE_LEVEL(1'b1)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(clean_lines[g])
        );
    end

    logic scl_f;
    logic sda_f;
    assign scl_f = clean_lines[0];
    assign sda_f = clean_lines[1];

    tw_events_t ev;
    tw_bus_events u_events (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_i(scl_f),
        .sda_i(sda_f),
        .ev_o (ev)
    );

    logic              mem_we;
    logic [BYTE_W-1:0] mem_rdata;
    tw_word_store #(
        .WORDS(WORDS),
        .WIDTH(BYTE_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mem_we),
        .waddr_i(q.wr_addr),
        .wdata_i(q.wr_data),
        .raddr_i(q.ptr),
        .rdata_o(mem_rdata)
    );

    logic [BYTE_W-1:0] byte_in;
    assign byte_in = {q.shift[BYTE_W-2:0], sda_f};

    // signals observed by the bound checker
    logic      hold_tick;
    logic      busy_w;
    logic      ev_start;
    logic      ev_stop;
    tw_state_e st_w;
    assign hold_tick = (q.hold_cnt == HW'(1));
    assign busy_w    = q.busy;
    assign ev_start  = ev.start;
    assign ev_stop   = ev.stop;
    assign st_w      = q.st;

    always_comb begin
        d      = q;
        mem_we = 1'b0;

        // programming interval
        if (q.busy) begin
            if (q.busy_cnt == BW'(1)) begin
                d.busy = 1'b0;
            end
            d.busy_cnt = q.busy_cnt - 1'b1;
        end

        // output hold delay after each bus clock fall
        if (q.hold_cnt != '0) begin
            d.hold_cnt = q.hold_cnt - 1'b1;
            if (q.hold_cnt == HW'(1)) begin
                d.oe = q.target;
            end
        end
        if (ev.scl_fall) begin
            d.hold_cnt = HW'(HOLD_CYC);
        end

        unique case (q.st)
            ST_CTRL, ST_ADDR, ST_WDATA: begin
                if (ev.scl_rise) begin
                    d.shift = byte_in;
                    if (q.bitcnt == 4'd7) begin
                        d.bitcnt = 4'd8;
                        d.st     = ST_ACK;
                        if (q.st == ST_CTRL) begin
                            if (byte_in[7:4] == DEV_CODE && !q.busy) begin
                                d.nxt = byte_in[0] ? ST_RDATA : ST_ADDR;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_ADDR) begin
                            d.ptr     = byte_in[AW-1:0];
                            d.wr_addr = byte_in[AW-1:0];
                            d.nxt     = ST_WDATA;
                        end else begin
                            d.wr_data = byte_in;
                            d.wr_pend = 1'b1;
                            d.nxt     = ST_IDLE;
                        end
                    end else begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                end
            end
            ST_ACK: begin
                if (ev.scl_fall) begin
                    if (q.bitcnt == 4'd8) begin
                        d.target = 1'b1;
                        d.bitcnt = 4'd9;
                    end else begin
                        d.st     = q.nxt;
                        d.bitcnt = '0;
                        if (q.nxt == ST_RDATA) begin
                            d.shift  = mem_rdata;
                            d.target = !mem_rdata[BYTE_W-1];
                        end else begin
                            d.target = 1'b0;
                        end
                    end
                end
            end
            ST_RDATA: begin
                if (ev.scl_rise) begin
                    if (q.bitcnt == 4'd7) begin
                        d.st     = ST_RACK;
                        d.bitcnt = '0;
                        d.ptr    = q.ptr + 1'b1;
                    end else begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                end else if (ev.scl_fall && q.bitcnt != '0) begin
                    d.shift  = {q.shift[BYTE_W-2:0], 1'b0};
                    d.target = !q.shift[BYTE_W-2];
                end
            end
            ST_RACK: begin
                if (ev.scl_fall) begin
                    if (q.bitcnt == '0) begin
                        d.target = 1'b0;
                    end else begin
                        d.st     = ST_RDATA;
                        d.bitcnt = '0;
                        d.shift  = mem_rdata;
                        d.target = !mem_rdata[BYTE_W-1];
                    end
                end else if (ev.scl_rise) begin
                    if (sda_f) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.bitcnt = 4'd1;
                    end
                end
            end
            default: begin
            end
        endcase

        // bus conditions override everything else
        if (ev.start) begin
            d.st       = ST_CTRL;
            d.bitcnt   = '0;
            d.wr_pend  = 1'b0;
            d.target   = 1'b0;
            d.oe       = 1'b0;
            d.hold_cnt = '0;
        end else if (ev.stop) begin
            d.st       = ST_IDLE;
            d.target   = 1'b0;
            d.oe       = 1'b0;
            d.hold_cnt = '0;
            if (q.wr_pend) begin
                mem_we     = 1'b1;
                d.wr_pend  = 1'b0;
                d.busy     = 1'b1;
                d.busy_cnt = BW'(WR_CYC);
                d.ptr      = q.wr_addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.nxt      <= ST_IDLE;
            q.bitcnt   <= '0;
            q.shift    <= '0;
            q.ptr      <= '0;
            q.wr_addr  <= '0;
            q.wr_data  <= '0;
            q.wr_pend  <= 1'b0;
            q.busy     <= 1'b0;
            q.busy_cnt <= '0;
            q.hold_cnt <= '0;
            q.target   <= 1'b0;
            q.oe       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk
    import tw_eeprom_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_f,
    input logic      sda_oe,
    input logic      hold_tick,
    input logic      busy_w,
    input logic      ev_start,
    input logic      ev_stop,
    input tw_state_e st_w
);
    assert_start_to_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (st_w == ST_CTRL));

    assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (st_w == ST_IDLE && !sda_oe));

    assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> !$rose(sda_oe));

    assert_no_drive_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> !$rose(sda_oe));

    assert_rise_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(hold_tick));

    assert_fall_timed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> ($past(hold_tick) || $past(ev_start) || $past(ev_stop)));

endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_oe   (sda_oe),
    .hold_tick(hold_tick),
    .busy_w   (busy_w),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .st_w     (st_w)
);

// File: tb/tw_eeprom_slave_bench.sv
`timescale 1ns/1ps
module tw_eeprom_slave_bench;
    localparam int GLITCH = 10;
    localparam int HOLD   = 60;
    localparam int WR     = 4000;

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{wr: 1'b1, addr: 4'd14, data: 8'h7E},
        '{wr: 1'b1, addr: 4'd15, data: 8'h3C},
        '{wr: 1'b1, addr: 4'd0,  data: 8'h81},
        '{wr: 1'b0, addr: 4'd15, data: 8'h00},
        '{wr: 1'b0, addr: 4'd14, data: 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    assign sda_line = ~(m_sda_low | sda_oe);

    always #2.5 clk = ~clk;

    tw_eeprom_slave #(
        .GLITCH_CYC(GLITCH),
        .HOLD_CYC  (HOLD),
        .WR_CYC    (WR)
    ) u_tw_eeprom_slave (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (m_scl),
        .sda_i (sda_line),
        .sda_oe(sda_oe)
    );

    int checks = 0;
    int errors = 0;
    int last_dly = 0;
    logic [7:0] model [16];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_cyc(80); m_sda_low = 1'b0;
        wait_cyc(20); m_scl = 1'b1;
        wait_cyc(50); m_sda_low = 1'b1;
        wait_cyc(50); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_cyc(80); m_sda_low = 1'b1;
        wait_cyc(20); m_scl = 1'b1;
        wait_cyc(50); m_sda_low = 1'b0;
        wait_cyc(50);
    endtask

    task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit ack);
        bit a1, a2;
        for (int i = 0; i < 8; i++) begin
            if (i == glitch_bit) begin
                wait_cyc(20); m_scl = 1'b1;
                wait_cyc(GLITCH); m_scl = 1'b0;
                wait_cyc(60 - GLITCH);
            end else begin
                wait_cyc(80);
            end
            m_sda_low = ~b[7-i];
            wait_cyc(20); m_scl = 1'b1;
            if (i == glitch_bit && b[7-i]) begin
                wait_cyc(20); m_sda_low = 1'b1;
                wait_cyc(GLITCH); m_sda_low = 1'b0;
                wait_cyc(80 - GLITCH);
            end else begin
                wait_cyc(100);
            end
            m_scl = 1'b0;
        end
        last_dly = 0;
        for (int c = 1; c <= 100; c++) begin
            @(negedge clk);
            if (c == 80) m_sda_low = 1'b0;
            if (sda_oe && last_dly == 0) last_dly = c;
        end
        m_scl = 1'b1;
        wait_cyc(10); a1 = ~sda_line;
        wait_cyc(85); a2 = ~sda_line;
        wait_cyc(5);  m_scl = 1'b0;
        ack = a1 && a2;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            wait_cyc(80); m_sda_low = 1'b0;
            wait_cyc(20); m_scl = 1'b1;
            wait_cyc(50); b[7-i] = sda_line;
            wait_cyc(50); m_scl = 1'b0;
        end
        wait_cyc(80); m_sda_low = mack;
        wait_cyc(20); m_scl = 1'b1;
        wait_cyc(100); m_scl = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] v, input int glitch_bit);
        bit k0, k1, k2;
        bus_start();
        send_byte(8'hA0, -1, k0);
        chk(k0, "R2/R4 control ack on write", int'(k0), 1);
        send_byte({4'h0, a}, -1, k1);
        chk(k1, "R5 address ack", int'(k1), 1);
        send_byte(v, glitch_bit, k2);
        chk(k2, glitch_bit >= 0 ? "R11 data ack despite spikes" : "R5/R7 data ack", int'(k2), 1);
        bus_stop();
        wait_cyc(5);
        chk(sda_oe == 1'b0, "R3 line released after STOP", int'(sda_oe), 0);
        model[a] = v;
        wait_cyc(WR + 500);
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] v);
        bit k0, k1, k2;
        bus_start();
        send_byte(8'hA0, -1, k0);
        send_byte({4'h0, a}, -1, k1);
        bus_start();
        send_byte(8'hA1, -1, k2);
        chk(k0 && k1 && k2, "R10 random read setup acks", int'({k0, k1, k2}), 7);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit k, k2;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        wait_cyc(20);
        rst_n = 1'b1;
        wait_cyc(20);

        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);

        // R8: ack timing measured on first control byte
        bus_start();
        send_byte(8'hA0, -1, k);
        chk(k, "R7 ack held through ninth clock high", int'(k), 1);
        chk(last_dly >= HOLD && last_dly <= HOLD + GLITCH + 8,
            "R8 ack delay after SCL fall", last_dly, HOLD + GLITCH + 4);
        bus_stop();

        // vector table
        foreach (VECS[n]) begin
            if (VECS[n].wr) begin
                do_write(VECS[n].addr, VECS[n].data, -1);
            end else begin
                do_read(VECS[n].addr, rd);
                chk(rd == model[VECS[n].addr], "R10 random read data", rd, model[VECS[n].addr]);
            end
        end

        // R9: sequential read wrapping 15 -> 0, don't-care control bits
        bus_start();
        send_byte(8'hA0, -1, k);
        send_byte(8'h0E, -1, k);
        bus_start();
        send_byte(8'hAB, -1, k);
        chk(k, "R4 control bits 3..1 ignored", int'(k), 1);
        recv_byte(1'b1, rd);
        chk(rd == 8'h7E, "R9 sequential byte 14", rd, 8'h7E);
        recv_byte(1'b1, rd);
        chk(rd == 8'h3C, "R9 sequential byte 15", rd, 8'h3C);
        recv_byte(1'b0, rd);
        chk(rd == 8'h81, "R9 pointer wraps to 0", rd, 8'h81);
        wait_cyc(90);
        chk(sda_oe == 1'b0, "R9 released after master nack", int'(sda_oe), 0);
        bus_stop();

        // R4: wrong device code
        bus_start();
        send_byte(8'h30, -1, k);
        chk(!k, "R4 foreign control byte not acked", int'(k), 0);
        send_byte(8'hA0, -1, k);
        chk(!k, "R4 ignored until next START", int'(k), 0);
        bus_stop();

        // R5/R6: second data byte refused, busy after commit
        bus_start();
        send_byte(8'hA0, -1, k);
        send_byte(8'h09, -1, k);
        send_byte(8'h44, -1, k);
        chk(k, "R5 first data byte acked", int'(k), 1);
        send_byte(8'h55, -1, k);
        chk(!k, "R5 second data byte not acked", int'(k), 0);
        bus_stop();
        bus_start();
        send_byte(8'hA0, -1, k);
        chk(!k, "R6 no ack while programming", int'(k), 0);
        bus_stop();
        wait_cyc(WR);
        do_read(4'd9, rd);
        chk(rd == 8'h44, "R5 only first data byte stored", rd, 8'h44);

        // R2/R5: repeated START drops pending write
        bus_start();
        send_byte(8'hA0, -1, k);
        send_byte(8'h0A, -1, k);
        send_byte(8'h99, -1, k);
        bus_start();
        send_byte(8'hA1, -1, k);
        recv_byte(1'b0, rd);
        chk(rd == 8'h00, "R1/R5 word 10 untouched by dropped write", rd, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'hA0, -1, k2);
        chk(k2, "R5 no programming interval after dropped write", int'(k2), 1);
        bus_stop();

        // R11: spikes on both lines inside a data byte
        do_write(4'd6, 8'hC3, 1);
        do_read(4'd6, rd);
        chk(rd == 8'hC3, "R11 spikes rejected", rd, 8'hC3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule